// File: doc/BRIEF.md
# Chip-Select and Transfer-Acknowledge Unit

This unit watches each processor bus cycle and turns its address into one active-low chip select from a small set of programmable regions. It also produces the transfer acknowledge that ends the cycle. A cycle opens when the active-low start strobe is sampled low while the unit is idle. The chosen select then stays low until an acknowledge is seen. The acknowledge is either raised internally after a per-region number of wait states or taken from a wired-OR external line driven by devices that can answer for themselves.

At reset, region 0 answers every address, so boot code can read its start vectors from nonvolatile memory at address zero. This global decode ends when software first writes the region 0 mask field. A separate window marks the on-chip register block. Its base can be moved in 1 KB steps, and it is acknowledged internally with no wait states. A small write port loads each region's base, mask and control fields.

Top module: `cs_ta_unit`

## Requirements
- R1: When `ts_n_i` is sampled low at a rising edge while no cycle is open, the decoded select (or `mod_sel_o`) is active from the next clock. It stays active until the clock in which `ta_n_o` is low, and it is released in the following clock.
- R2: After reset, region 0 matches every address until the region 0 mask field is written. Every reset brings this global decode back.
- R3: After a write to the region 0 mask field, region 0 matches only its programmed base and mask.
- R4: Region k matches when its valid bit is set and address bits 31:16 equal its base in every bit position where its mask bit is 0. An invalid region never matches.
- R5: At most one of the chip selects and `mod_sel_o` is active at a time. When regions overlap, the lowest-numbered matching region wins.
- R6: With the internal acknowledge enabled and wait count N (0..15), `ta_n_o` goes low in clock N+1 after the strobe was sampled, for exactly one clock.
- R7: With the internal acknowledge disabled, the cycle stays open until `ext_ta_n_i` is low.
- R8: A low on `ext_ta_n_i` during an open cycle drives `ta_n_o` low in that clock and completes the cycle, even before the wait count expires.
- R9: The register window matches the 1 KB page whose address bits 31:10 equal its base register (reset value 0x10000000). It takes priority over every region, asserts `mod_sel_o`, and is acknowledged in clock 1.
- R10: An address that matches nothing asserts no chip select and no internal acknowledge. Only the external acknowledge ends that cycle.
- R11: A strobe seen while a cycle is open is ignored. The open cycle keeps its select, and no new cycle follows it.
- R12: Reset values are as follows:
  - region 0: base 0xFFE0, mask 0x0003, wait 3, acknowledge enabled;
  - region 1: invalid;
  - region 2: base 0x3000, mask 0x000F, wait 2, acknowledge enabled;
  - region 3: base 0x4000, mask 0x000F, acknowledge disabled;
  - all outputs inactive.
- R13: Config writes decode `cfg_addr_i` as {index[4:2], field[1:0]}:
  - For index k below 4: field 0 holds the base (A31:16), field 1 holds the mask (A31:16), and field 2 holds control, with bit 5 valid, bit 4 acknowledge enable and bits 3:0 the wait count. Field 3 is ignored.
  - For index 4: field 0 holds base A31:16 and field 1 holds base A15:10 in data bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_n_i | input | 1 | Asynchronous active-low reset |
| ts_n_i | input | 1 | Active-low transfer-start strobe |
| addr_i | input | 22 | Bus address bits 31:10 |
| ext_ta_n_i | input | 1 | Wired external acknowledge, active low |
| cfg_we_i | input | 1 | Config write enable |
| cfg_addr_i | input | 5 | Config field address {index, field} |
| cfg_data_i | input | 16 | Config write data |
| cs_n_o | output | 4 | Active-low chip selects |
| mod_sel_o | output | 1 | Register window selected |
| ta_n_o | output | 1 | Merged active-low transfer acknowledge |

## Verification
Addresses are placed at the first and last page of each region and just past its end. This separates the mask compare from an off-by-one in the base. The same addresses are replayed during the boot phase, after the region 0 mask write, and after a second reset. This distinguishes global decode from regional decode. External acknowledges are timed before, at and after the internal count, which shows whether the merge and the wait counter each end the cycle on their own. Overlapping regions, an invalidated region and a strobe repeated mid-cycle test priority, the valid bit and strobe filtering.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int HI_W   = 16;  // region compare covers address bits 31:16
  localparam int WAIT_W = 4;
  localparam int PAGE_W = 22;  // address bits 31:10
  localparam int LO_W   = PAGE_W - HI_W;

  typedef struct packed {
    logic [HI_W-1:0]   base;
    logic [HI_W-1:0]   mask;
    logic              valid;
    logic              ack_en;
    logic [WAIT_W-1:0] wait_n;
  } region_cfg_t;

  typedef enum logic [1:0] {
    F_BASE  = 2'd0,
    F_MASK  = 2'd1,
    F_CTRL  = 2'd2,
    F_SPARE = 2'd3
  } field_e;

  localparam int CTRL_VALID = 5;
  localparam int CTRL_ACK   = 4;

  localparam logic [PAGE_W-1:0] MOD_BASE_RST = 22'h04_0000;

  function automatic region_cfg_t region_rst(int idx);
    region_cfg_t r;
    r = '0;
    case (idx)
      0: r = '{base: 16'hFFE0, mask: 16'h0003, valid: 1'b1, ack_en: 1'b1, wait_n: 4'd3};
      2: r = '{base: 16'h3000, mask: 16'h000F, valid: 1'b1, ack_en: 1'b1, wait_n: 4'd2};
      3: r = '{base: 16'h4000, mask: 16'h000F, valid: 1'b1, ack_en: 1'b0, wait_n: 4'd0};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [1:0]          fld_i,
  input  logic [HI_W-1:0]     data_i,
  output region_cfg_t         cfg_o [NUM_CS],
  output logic [PAGE_W-1:0]   mod_base_o,
  output logic                boot_o
);
  region_cfg_t       cfg_q [NUM_CS];
  region_cfg_t       cfg_d [NUM_CS];
  logic [PAGE_W-1:0] mod_q, mod_d;
  logic              boot_q, boot_d;

  always_comb begin
    for (int k = 0; k < NUM_CS; k++) begin
      cfg_d[k] = cfg_q[k];
      if (we_i && int'(idx_i) == k) begin
        case (field_e'(fld_i))
          F_BASE: cfg_d[k].base = data_i;
          F_MASK: cfg_d[k].mask = data_i;
          F_CTRL: begin
            cfg_d[k].valid  = data_i[CTRL_VALID];
            cfg_d[k].ack_en = data_i[CTRL_ACK];
            cfg_d[k].wait_n = data_i[WAIT_W-1:0];
          end
          default: ;
        endcase
      end
    end
    mod_d = mod_q;
    if (we_i && int'(idx_i) == NUM_CS) begin
      if (field_e'(fld_i) == F_BASE) mod_d[PAGE_W-1:LO_W] = data_i;
      if (field_e'(fld_i) == F_MASK) mod_d[LO_W-1:0]      = data_i[LO_W-1:0];
    end
    boot_d = boot_q;
    if (we_i && idx_i == '0 && field_e'(fld_i) == F_MASK) boot_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int k = 0; k < NUM_CS; k++) cfg_q[k] <= region_rst(k);
      mod_q  <= MOD_BASE_RST;
      boot_q <= 1'b1;
    end else begin
      for (int k = 0; k < NUM_CS; k++) cfg_q[k] <= cfg_d[k];
      mod_q  <= mod_d;
      boot_q <= boot_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign mod_base_o = mod_q;
  assign boot_o     = boot_q;

  assert_boot_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (we_i && idx_i == '0 && fld_i == 2'd1) |=> !boot_q);

  assert_boot_once_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !boot_q |=> !boot_q);
endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic [PAGE_W-1:0] addr_i,
  input  region_cfg_t       cfg_i [NUM_CS],
  input  logic [PAGE_W-1:0] mod_base_i,
  input  logic              boot_i,
  output logic [NUM_CS-1:0] sel_o,
  output logic              mod_hit_o,
  output logic              ack_en_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic [NUM_CS-1:0] match;

  always_comb begin
    for (int k = 0; k < NUM_CS; k++) begin
      match[k] = cfg_i[k].valid &&
                 (((addr_i[PAGE_W-1:LO_W] ^ cfg_i[k].base) & ~cfg_i[k].mask) == '0);
    end
    match[0] = match[0] | boot_i;
  end

  assign mod_hit_o = (addr_i == mod_base_i);

  always_comb begin
    sel_o    = '0;
    ack_en_o = 1'b0;
    wait_o   = '0;
    for (int k = NUM_CS - 1; k >= 0; k--) begin
      if (match[k]) begin
        sel_o    = '0;
        sel_o[k] = 1'b1;
        ack_en_o = cfg_i[k].ack_en;
        wait_o   = cfg_i[k].wait_n;
      end
    end
    if (mod_hit_o) begin
      sel_o    = '0;
      ack_en_o = 1'b1;
      wait_o   = '0;
    end
  end
endmodule

// File: rtl/cs_cycle_ctl.sv
module cs_cycle_ctl
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              ts_n_i,
  input  logic              ext_ta_n_i,
  input  logic [NUM_CS-1:0] sel_i,
  input  logic              mod_hit_i,
  input  logic              ack_en_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              mod_sel_o,
  output logic              ta_n_o
);
  logic              busy_q, busy_d;
  logic [NUM_CS-1:0] cs_q, cs_d;
  logic              mod_q, mod_d;
  logic              en_q, en_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              int_ack, ack_now;

  assign int_ack = busy_q && en_q && (cnt_q == '0);
  assign ack_now = int_ack || (busy_q && !ext_ta_n_i);

  always_comb begin
    busy_d = busy_q;
    cs_d   = cs_q;
    mod_d  = mod_q;
    en_d   = en_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (!ts_n_i) begin
        busy_d = 1'b1;
        cs_d   = sel_i;
        mod_d  = mod_hit_i;
        en_d   = ack_en_i;
        cnt_d  = wait_i;
      end
    end else if (ack_now) begin
      busy_d = 1'b0;
      cs_d   = '0;
      mod_d  = 1'b0;
      en_d   = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b0;
      cs_q   <= '0;
      mod_q  <= 1'b0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cs_q   <= cs_d;
      mod_q  <= mod_d;
      en_q   <= en_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cs_n_o    = ~cs_q;
  assign mod_sel_o = mod_q;
  assign ta_n_o    = ~ack_now;

  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!busy_q && !ts_n_i) |=> busy_q);

  assert_release_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && ack_now) |=> (cs_q == '0 && !mod_q));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && !ack_now) |=> (busy_q && $stable(cs_q) && $stable(mod_q)));

  assert_ack_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    int_ack |=> !int_ack);

  assert_one_select_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0({cs_q, mod_q}));

  assert_no_match_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && cs_q == '0 && !mod_q) |-> !int_ack);
endmodule

// File: rtl/cs_ta_unit.sv
module cs_ta_unit
  import cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W  = $clog2(NUM_CS + 1),
  localparam int CFG_AW = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              arst_n_i,
  input  logic              ts_n_i,
  input  logic [PAGE_W-1:0] addr_i,
  input  logic              ext_ta_n_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [HI_W-1:0]   cfg_data_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              mod_sel_o,
  output logic              ta_n_o
);
  logic              rst_n;
  region_cfg_t       cfg [NUM_CS];
  logic [PAGE_W-1:0] mod_base;
  logic              boot;
  logic [NUM_CS-1:0] sel;
  logic              mod_hit;
  logic              ack_en;
  logic [WAIT_W-1:0] wait_n;

  cs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (rst_n)
  );

  cs_cfg_regs #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regs (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .we_i       (cfg_we_i),
    .idx_i      (cfg_addr_i[CFG_AW-1:2]),
    .fld_i      (cfg_addr_i[1:0]),
    .data_i     (cfg_data_i),
    .cfg_o      (cfg),
    .mod_base_o (mod_base),
    .boot_o     (boot)
  );

  cs_addr_decode #(.NUM_CS(NUM_CS)) u_dec (
    .addr_i     (addr_i),
    .cfg_i      (cfg),
    .mod_base_i (mod_base),
    .boot_i     (boot),
    .sel_o      (sel),
    .mod_hit_o  (mod_hit),
    .ack_en_o   (ack_en),
    .wait_o     (wait_n)
  );

  cs_cycle_ctl #(.NUM_CS(NUM_CS)) u_ctl (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .ts_n_i     (ts_n_i),
    .ext_ta_n_i (ext_ta_n_i),
    .sel_i      (sel),
    .mod_hit_i  (mod_hit),
    .ack_en_i   (ack_en),
    .wait_i     (wait_n),
    .cs_n_o     (cs_n_o),
    .mod_sel_o  (mod_sel_o),
    .ta_n_o     (ta_n_o)
  );
endmodule

// File: tb/tb_cs_ta_unit.sv
module tb_cs_ta_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [21:0] a;
    logic [7:0]  ext;
    logic [3:0]  cs;
    logic        md;
    logic [7:0]  ack;
  } vec_t;

  // region 0 wait 3 -> ack 4, region 2 wait 2 -> ack 3, region 3 external only
  localparam vec_t VECS [NV] = '{
    '{22'h3FF800, 8'd0, 4'b0001, 1'b0, 8'd4},  // R3 region 0 first page
    '{22'h3FF8FF, 8'd0, 4'b0001, 1'b0, 8'd4},  // R4 region 0 last page
    '{22'h3FF900, 8'd3, 4'b0000, 1'b0, 8'd3},  // R10 just past region 0
    '{22'h0C0000, 8'd0, 4'b0100, 1'b0, 8'd3},  // R6 region 2
    '{22'h0C03FF, 8'd0, 4'b0100, 1'b0, 8'd3},  // R4 region 2 last page
    '{22'h0C0400, 8'd2, 4'b0000, 1'b0, 8'd2},  // R10 past region 2
    '{22'h100000, 8'd6, 4'b1000, 1'b0, 8'd6},  // R7 region 3 external
    '{22'h040000, 8'd0, 4'b0000, 1'b1, 8'd1},  // R9 register window
    '{22'h040001, 8'd1, 4'b0000, 1'b0, 8'd1},  // R9 next page misses
    '{22'h000000, 8'd2, 4'b0000, 1'b0, 8'd2},  // R3 zero no longer region 0
    '{22'h0C0000, 8'd1, 4'b0100, 1'b0, 8'd1},  // R8 early external
    '{22'h3FF800, 8'd2, 4'b0001, 1'b0, 8'd2}   // R8 external before count
  };

  logic        clk = 1'b0;
  logic        arst_n, ts_n, ext_ta_n, cfg_we;
  logic [21:0] addr;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic [3:0]  cs_n;
  logic        mod_sel, ta_n;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_ta_unit dut (
    .clk_i(clk), .arst_n_i(arst_n), .ts_n_i(ts_n), .addr_i(addr),
    .ext_ta_n_i(ext_ta_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .cs_n_o(cs_n), .mod_sel_o(mod_sel), .ta_n_o(ta_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] idx, input logic [1:0] fld, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {idx, fld}; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cycle(input logic [21:0] a, input int ext_at, input logic [3:0] exp_cs,
                           input logic exp_md, input int exp_ack, input string req);
    int ack_clk = 0;
    @(negedge clk);
    addr = a; ts_n = 1'b0;
    @(negedge clk);
    ts_n = 1'b1;
    for (int c = 1; c <= 40; c++) begin
      ext_ta_n = (c == ext_at) ? 1'b0 : 1'b1;
      #1;
      if (c == 1) begin
        chk(cs_n == ~exp_cs, req, "select in clock 1", {28'd0, cs_n}, {28'd0, ~exp_cs});
        chk(mod_sel == exp_md, req, "window select", {31'd0, mod_sel}, {31'd0, exp_md});
      end
      if (!ta_n) begin
        ack_clk = c;
        break;
      end
      @(negedge clk);
    end
    chk(ack_clk == exp_ack, req, "acknowledge clock", ack_clk, exp_ack);
    @(negedge clk);
    ext_ta_n = 1'b1;
    #1;
    chk(cs_n == 4'hF && !mod_sel && ta_n, req, "release after ack",
        {27'd0, cs_n, mod_sel}, 32'h1E);
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n == 4'hF && !mod_sel && ta_n, "R12", "outputs in reset",
        {26'd0, cs_n, mod_sel, ta_n}, 32'h3D);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b1; ts_n = 1'b1; ext_ta_n = 1'b1; cfg_we = 1'b0;
    addr = '0; cfg_addr = '0; cfg_data = '0;
    do_reset();
    #1;
    chk(cs_n == 4'hF && ta_n && !mod_sel, "R12", "idle after reset",
        {26'd0, cs_n, mod_sel, ta_n}, 32'h3D);

    // R2 boot phase: region 0 answers everything except the register window
    run_cycle(22'h000000, 0, 4'b0001, 1'b0, 4, "R2");
    run_cycle(22'h0C0000, 0, 4'b0001, 1'b0, 4, "R2");
    run_cycle(22'h100000, 0, 4'b0001, 1'b0, 4, "R2");
    run_cycle(22'h040000, 0, 4'b0000, 1'b1, 1, "R9");

    cfg_wr(3'd0, 2'd1, 16'h0003);  // R3 mask write ends global decode

    for (int i = 0; i < NV; i++)
      run_cycle(VECS[i].a, int'(VECS[i].ext), VECS[i].cs, VECS[i].md,
                int'(VECS[i].ack), "R1");

    // R11 strobe during an open cycle is ignored
    @(negedge clk); addr = 22'h100000; ts_n = 1'b0;
    @(negedge clk); ts_n = 1'b1;
    @(negedge clk); addr = 22'h0C0000; ts_n = 1'b0; #1;
    chk(cs_n == 4'b0111, "R11", "select held", {28'd0, cs_n}, 32'h7);
    @(negedge clk); ts_n = 1'b1;
    @(negedge clk); ext_ta_n = 1'b0; #1;
    chk(!ta_n, "R7", "external ack passes", {31'd0, ta_n}, 32'h0);
    @(negedge clk); ext_ta_n = 1'b1; #1;
    chk(cs_n == 4'hF, "R11", "no second cycle", {28'd0, cs_n}, 32'hF);
    @(negedge clk); #1;
    chk(cs_n == 4'hF && ta_n, "R11", "still idle", {27'd0, cs_n, ta_n}, 32'h1F);

    // R4 invalid region never matches
    cfg_wr(3'd2, 2'd2, 16'h0012);
    run_cycle(22'h0C0000, 2, 4'b0000, 1'b0, 2, "R4");
    cfg_wr(3'd2, 2'd2, 16'h0032);

    // R5 overlapping region 1 beats region 2
    cfg_wr(3'd1, 2'd0, 16'h3000);
    cfg_wr(3'd1, 2'd1, 16'h000F);
    cfg_wr(3'd1, 2'd2, 16'h0031);
    run_cycle(22'h0C0000, 0, 4'b0010, 1'b0, 2, "R5");

    // R6 wait count limits
    cfg_wr(3'd0, 2'd2, 16'h0030);
    run_cycle(22'h3FF800, 0, 4'b0001, 1'b0, 1, "R6");
    cfg_wr(3'd0, 2'd2, 16'h003F);
    run_cycle(22'h3FF800, 0, 4'b0001, 1'b0, 16, "R6");
    cfg_wr(3'd0, 2'd3, 16'h0000);  // R13 spare field ignored
    run_cycle(22'h3FF800, 0, 4'b0001, 1'b0, 16, "R13");

    // R9 register window relocated to 0x20000400
    cfg_wr(3'd4, 2'd0, 16'h2000);
    cfg_wr(3'd4, 2'd1, 16'h0001);
    run_cycle(22'h080001, 0, 4'b0000, 1'b1, 1, "R9");
    run_cycle(22'h040000, 3, 4'b0000, 1'b0, 3, "R9");

    // R4 mask narrowed to a single 64 KB block
    cfg_wr(3'd0, 2'd1, 16'h0000);
    run_cycle(22'h3FF840, 3, 4'b0000, 1'b0, 3, "R4");
    run_cycle(22'h3FF800, 0, 4'b0001, 1'b0, 16, "R4");

    // R2 second reset restores global decode and defaults
    do_reset();
    run_cycle(22'h0C0000, 0, 4'b0001, 1'b0, 4, "R2");
    cfg_wr(3'd0, 2'd1, 16'h0003);
    run_cycle(22'h0C0000, 0, 4'b0100, 1'b0, 3, "R12");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule